// File: doc/BRIEF.md
# Two-Entry Elastic Pipeline Stage

This block is a single stage for a latency-insensitive pipeline. It sits between an upstream channel (data, a forward valid wire, a backward stop wire it drives) and a downstream channel (data, a valid wire it drives, a stop wire it receives). A token moves across a channel in any cycle where valid is high and stop is low. When valid is low the channel is idle, and the stop wire has no meaning. When both wires are high the sender retries: it must keep presenting the same token. The stage holds tokens while its consumer stalls. It never drops a token and never sends one twice.

Two flip-flop entries are provided: a head entry that drives the output and a spare entry that catches a token when the consumer stalls. With both entries, the stop wire towards the producer can come straight from a register and throughput still reaches one token per cycle. The control is a three-state machine. `ST_EMPTY` moves to `ST_ONE` on an accept. `ST_ONE` moves to `ST_TWO` when it accepts while stalled, and back to `ST_EMPTY` when it delivers without accepting. `ST_TWO` moves to `ST_ONE` when it delivers. A parameter sets whether the stage leaves reset empty (a bubble, which adds latency and changes nothing else) or holding one token of a programmable value.

Top module: `elastic_stage`

## Requirements
- R1: With INIT_TOKEN=0, during and right after reset `dn_valid` is 0 and `up_stop` is 0.
- R2: With INIT_TOKEN=1, after reset `dn_valid` is 1 and `dn_data` equals INIT_VALUE until that token is taken downstream. Once it is taken, `dn_valid` is 0.
- R3: A token is accepted only at a clock edge where `up_valid`=1 and `up_stop`=0. While `up_stop`=1 a presented token is not taken.
- R4: Every accepted token is delivered exactly once, in arrival order, with its data unchanged.
- R5: During a downstream retry (`dn_valid`=1 and `dn_stop`=1) the next cycle still shows `dn_valid`=1 with identical `dn_data`.
- R6: `up_stop` is a register output. It is 1 only while both entries are occupied. It rises in the cycle after a second token is stored while the consumer stalls, and stays high while the consumer keeps stalling.
- R7: When `dn_stop` stays 0, a token accepted at an edge is shown on `dn_valid`/`dn_data` right after that edge, and back-to-back tokens are accepted one per cycle with no stall.
- R8: `dn_stop` asserted while `dn_valid`=0 has no effect: `up_stop` stays 0 and a new token is still accepted.
- R9: From the full state, a downstream transfer clears `up_stop` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| up_data | input | WIDTH | Token data from the producer |
| up_valid | input | 1 | Producer presents a token |
| up_stop | output | 1 | Stage cannot take a token this cycle (registered) |
| dn_data | output | WIDTH | Token data to the consumer |
| dn_valid | output | 1 | Stage presents a token |
| dn_stop | input | 1 | Consumer refuses the token this cycle |

## Verification
The hardest case to reach is a producer that is retrying against a raised `up_stop` at the same moment the consumer releases its stall. In that case the spare entry moves into the head, and the waiting token must be taken exactly one cycle later. The stimulus reaches this state by first holding `dn_stop` high and pushing two tokens. It then presents a third token while the stage is full and drops `dn_stop` while that token is still waiting. A random stop pattern combined with random gaps in the producer's tokens then repeats the same state changes many times, and a scoreboard checks the order of the delivered tokens.

// File: rtl/eb_pkg.sv
package eb_pkg;

    // Occupancy of the two-entry stage
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ONE   = 2'd1,
        ST_TWO   = 2'd2
    } occ_e;

    // Load strobes from control to storage
    typedef struct packed {
        logic head_from_in;
        logic head_from_spare;
        logic spare_from_in;
    } eb_load_t;

endpackage

// File: rtl/eb_ctrl.sv
module eb_ctrl
    import eb_pkg::*;
#(
    parameter bit INIT_TOKEN = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     up_valid,
    input  logic     dn_stop,
    output logic     up_stop,
    output logic     dn_valid,
    output eb_load_t load
);

    localparam occ_e RESET_STATE = INIT_TOKEN ? ST_ONE : ST_EMPTY;

    occ_e state_q;
    occ_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (up_valid) begin
                    state_d = ST_ONE;           // accept
                end
            end
            ST_ONE: begin
                if (up_valid && dn_stop) begin
                    state_d = ST_TWO;           // accept while stalled
                end else if (!up_valid && !dn_stop) begin
                    state_d = ST_EMPTY;         // deliver only
                end
            end
            ST_TWO: begin
                if (!dn_stop) begin
                    state_d = ST_ONE;           // deliver, spare moves up
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // Outputs and load strobes
    always_comb begin
        up_stop  = 1'b0;
        dn_valid = 1'b0;
        load     = '0;
        unique case (state_q)
            ST_EMPTY: begin
                load.head_from_in = up_valid;
            end
            ST_ONE: begin
                dn_valid           = 1'b1;
                load.head_from_in  = up_valid && !dn_stop;
                load.spare_from_in = up_valid && dn_stop;
            end
            ST_TWO: begin
                dn_valid             = 1'b1;
                up_stop              = 1'b1;
                load.head_from_spare = !dn_stop;
            end
            default: begin
                up_stop  = 1'b0;
                dn_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/eb_store.sv
module eb_store
    import eb_pkg::*;
#(
    parameter int               WIDTH      = 8,
    parameter bit               INIT_TOKEN = 1'b0,
    parameter logic [WIDTH-1:0] INIT_VALUE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  eb_load_t         load,
    input  logic [WIDTH-1:0] in_data,
    output logic [WIDTH-1:0] head_data
);

    localparam logic [WIDTH-1:0] HEAD_RST = INIT_TOKEN ? INIT_VALUE : '0;

    logic [WIDTH-1:0] head_q;
    logic [WIDTH-1:0] spare_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= HEAD_RST;
        end else if (load.head_from_in) begin
            head_q <= in_data;
        end else if (load.head_from_spare) begin
            head_q <= spare_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_q <= '0;
        end else if (load.spare_from_in) begin
            spare_q <= in_data;
        end
    end

    assign head_data = head_q;

endmodule

// File: rtl/elastic_stage.sv
module elastic_stage
    import eb_pkg::*;
#(
    parameter int               WIDTH      = 8,
    parameter bit               INIT_TOKEN = 1'b0,
    parameter logic [WIDTH-1:0] INIT_VALUE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] up_data,
    input  logic             up_valid,
    output logic             up_stop,
    output logic [WIDTH-1:0] dn_data,
    output logic             dn_valid,
    input  logic             dn_stop
);

    eb_load_t load;

    eb_ctrl #(
        .INIT_TOKEN(INIT_TOKEN)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_valid(up_valid),
        .dn_stop (dn_stop),
        .up_stop (up_stop),
        .dn_valid(dn_valid),
        .load    (load)
    );

    eb_store #(
        .WIDTH     (WIDTH),
        .INIT_TOKEN(INIT_TOKEN),
        .INIT_VALUE(INIT_VALUE)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .in_data  (up_data),
        .head_data(dn_data)
    );

endmodule

// File: rtl/eb_checker.sv
module eb_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_valid,
    input logic             up_stop,
    input logic [WIDTH-1:0] dn_data,
    input logic             dn_valid,
    input logic             dn_stop
);

    // R5: retry holds valid and data
    a_r5_retry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && dn_stop |=> dn_valid && $stable(dn_data));

    // R6: stop only with tokens held
    a_r6_stop_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
        up_stop |-> dn_valid);

    // R6: empty stage cannot become full in one step
    a_r6_no_jump_full: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_valid |=> !up_stop);

    // R6: stays full while consumer stalls
    a_r6_stall_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        up_stop && dn_stop |=> up_stop);

    // R9: delivery from full clears stop
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        up_stop && !dn_stop |=> !up_stop);

    // R7: accepted token shows next cycle
    a_r7_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && !up_stop |=> dn_valid);

endmodule

bind elastic_stage eb_checker #(.WIDTH(WIDTH)) u_eb_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(up_valid),
    .up_stop (up_stop),
    .dn_data (dn_data),
    .dn_valid(dn_valid),
    .dn_stop (dn_stop)
);

// File: tb/tb_elastic_stage.sv
module tb_elastic_stage;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] up_data = '0;
    logic       up_valid = 1'b0;
    logic       up_stop;
    logic [7:0] dn_data;
    logic       dn_valid;
    logic       dn_stop = 1'b0;

    // token-initialised instance
    logic       tk_stop = 1'b1;
    logic       tk_up_stop;
    logic [7:0] tk_data;
    logic       tk_valid;

    int errors = 0;
    int checks = 0;
    int retry_cycles = 0;
    int sent = 0;
    int recvd = 0;
    int ds_mode = 0;
    logic [7:0] lfsr = 8'h5B;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    elastic_stage #(.WIDTH(8), .INIT_TOKEN(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .up_data(up_data), .up_valid(up_valid),
        .up_stop(up_stop), .dn_data(dn_data), .dn_valid(dn_valid), .dn_stop(dn_stop)
    );

    elastic_stage #(.WIDTH(8), .INIT_TOKEN(1'b1), .INIT_VALUE(8'hA5)) dut_tok (
        .clk(clk), .rst_n(rst_n), .up_data(8'h00), .up_valid(1'b0),
        .up_stop(tk_up_stop), .dn_data(tk_data), .dn_valid(tk_valid), .dn_stop(tk_stop)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // downstream stop pattern, applied at falling edges
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        unique case (ds_mode)
            0: dn_stop <= 1'b0;
            1: dn_stop <= 1'b1;
            default: dn_stop <= lfsr[0] ^ lfsr[2];
        endcase
    end

    // driver: R3 accept only when up_stop low at the edge
    task automatic send(input logic [7:0] d);
        logic seen;
        @(negedge clk);
        up_valid = 1'b1;
        up_data  = d;
        forever begin
            seen = up_stop;
            @(posedge clk);
            if (!seen) break;
            retry_cycles++;
            @(negedge clk);
        end
        exp_q.push_back(d);
        sent++;
    endtask

    task automatic idle();
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: scoreboard for R4, retry check for R5
    initial begin
        logic       held = 1'b0;
        logic [7:0] prev = '0;
        logic [7:0] e;
        forever begin
            @(negedge clk);
            #1;
            if (!rst_n) begin
                held = 1'b0;
                continue;
            end
            if (held) begin
                check(dn_valid && dn_data == prev, "R5 retry hold", {dn_valid, dn_data}, {1'b1, prev});
            end
            held = dn_valid && dn_stop;
            prev = dn_data;
            if (dn_valid && !dn_stop) begin
                recvd++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected token", dn_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(dn_data == e, "R4 order/data", dn_data, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        // R1: bubble stage in reset
        check(dn_valid == 1'b0 && up_stop == 1'b0, "R1 reset", {dn_valid, up_stop}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(dn_valid == 1'b0 && up_stop == 1'b0, "R1 after reset", {dn_valid, up_stop}, 0);
        // R2: token stage
        check(tk_valid == 1'b1 && tk_data == 8'hA5, "R2 init token", {tk_valid, tk_data}, 9'h1A5);
        @(negedge clk);
        #2;
        check(tk_valid == 1'b1 && tk_data == 8'hA5, "R2 token held", {tk_valid, tk_data}, 9'h1A5);
        tk_stop = 1'b0;
        @(negedge clk);
        #2;
        check(tk_valid == 1'b0, "R2 token taken", tk_valid, 0);

        // R7: latency
        send(8'h11);
        idle();
        #2;
        check(dn_valid && dn_data == 8'h11, "R7 latency", {dn_valid, dn_data}, 9'h111);
        drain();

        // R7: back-to-back throughput
        r0 = retry_cycles;
        for (int i = 0; i < 8; i++) send(8'h20 + 8'(i));
        idle();
        check(retry_cycles == r0, "R7 no stall", retry_cycles - r0, 0);
        drain();

        // R6/R3/R9: fill under stall, retry, release
        ds_mode = 1;
        @(negedge clk);
        send(8'h31);
        idle();
        #2;
        check(up_stop == 1'b0, "R6 one entry no stop", up_stop, 0);
        send(8'h32);
        idle();
        #2;
        check(up_stop == 1'b1, "R6 full stop", up_stop, 1);
        r0 = retry_cycles;
        fork
            send(8'h33);
            begin
                repeat (3) @(negedge clk);
                #3;
                check(up_stop == 1'b1, "R6 stays full", up_stop, 1);
                ds_mode = 0;
                @(negedge clk);
                @(negedge clk);
                #2;
                check(up_stop == 1'b0, "R9 stop cleared", up_stop, 0);
            end
        join
        idle();
        check(retry_cycles > r0, "R3 retry seen", retry_cycles - r0, 1);
        drain();

        // R8: stop while empty
        ds_mode = 1;
        repeat (2) @(negedge clk);
        #2;
        check(dn_valid == 1'b0 && up_stop == 1'b0, "R8 stop on empty", {dn_valid, up_stop}, 0);
        send(8'h44);
        idle();
        #2;
        check(dn_valid == 1'b1 && up_stop == 1'b0, "R8 accepted", {dn_valid, up_stop}, 2);
        ds_mode = 0;
        drain();

        // R4: random stop and gaps
        ds_mode = 2;
        for (int i = 0; i < 80; i++) begin
            send(8'($urandom));
            if ($urandom % 4 == 0) begin
                idle();
                repeat ($urandom % 3) @(negedge clk);
            end
        end
        idle();
        ds_mode = 0;
        drain();

        check(exp_q.size() == 0, "R4 nothing lost", exp_q.size(), 0);
        check(recvd == sent, "R4 count", recvd, sent);
        finish_run();
    end

endmodule